// File: doc/BRIEF.md
# Extended-Precision Add Special-Operand Resolver

This unit sits in front of an 80-bit extended floating-point adder. It looks at both operands and decides whether the sum can be settled without arithmetic. A special operand is a zero, an infinity, a quiet or signaling NaN, a denormal, or an encoding the format does not support. Each operand has a sign bit, a 15-bit biased exponent and a 64-bit significand whose top bit is an explicit integer bit.

When a special operand is present, the unit produces the final result and the invalid-operation and denormal flags. When both operands are finite and nonzero, it only signals that the main adder must do the work. A source that came from an integer conversion is flagged, so that an integer zero always counts as a positive zero. The rounding mode matters only for the sign of an exact zero sum.

Top module: `fadd_special_unit`

## Requirements
- R1: Outputs appear on the clock edge after a cycle with `in_valid_i` high. Exactly one of `spec_valid_o` and `use_adder_o` is high in that cycle. After a cycle without `in_valid_i`, both strobes and both flags are low.
- R2: When both operands are finite and nonzero, the unit raises `use_adder_o` and not `spec_valid_o`. An operand is finite and nonzero when it is normal (exponent neither 0 nor all ones, integer bit 1) or denormal (exponent 0, significand nonzero).
- R3: Two infinities of the same sign give that infinity, with no invalid flag. An infinity has exponent all ones and significand 0x8000_0000_0000_0000.
- R4: Two infinities of opposite sign raise `flag_ia_o` and give the indefinite NaN. The indefinite NaN has sign 1, exponent all ones and significand 0xC000_0000_0000_0000.
- R5: An infinity added to a finite value or a zero gives that infinity unchanged.
- R6: Two zeros of the same sign give that zero. Two zeros of opposite sign give +0, except in rounding mode 01 (toward minus infinity), which gives -0. The rounding-mode codes are 00 nearest, 01 down, 10 up, 11 toward zero.
- R7: When `src_int_i` is set, a zero source counts as +0 whatever its sign bit.
- R8: A zero added to a finite nonzero value gives that value unchanged.
- R9: If exactly one operand is a NaN, the result is that NaN with significand bit 62 set, so a quiet NaN passes through unchanged. A NaN has exponent all ones, integer bit 1, and a nonzero lower fraction; bit 62 set means quiet. `flag_ia_o` is raised only when a signaling NaN or an unsupported encoding is present.
- R10: If both operands are NaNs, the result is the one whose full 64-bit significand is larger, quieted. On a tie the destination is chosen.
- R11: An unsupported encoding raises `flag_ia_o`. An encoding is unsupported when the exponent is nonzero and the integer bit is 0. The result is then the indefinite NaN, unless the other operand is a NaN.
- R12: `flag_d_o` is raised when either operand is denormal and neither operand is a NaN or an unsupported encoding. This holds whether the result is special or goes to the adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid this cycle |
| dst_i | input | 80 | Destination operand |
| src_i | input | 80 | Source operand |
| src_int_i | input | 1 | Source was converted from an integer |
| round_mode_i | input | 2 | Rounding mode code |
| spec_valid_o | output | 1 | Special result valid |
| spec_result_o | output | 80 | Special result |
| use_adder_o | output | 1 | Operands must go to the main adder |
| flag_ia_o | output | 1 | Invalid-operation flag |
| flag_d_o | output | 1 | Denormal-operand flag |

## Verification
The hardest situations to produce are those where several special rules compete in one operation. Examples are a signaling NaN paired with a denormal, where the denormal flag must stay low, and a NaN paired with an unsupported encoding. Another is two NaNs whose significands differ only below the quiet bit. A negative-signed integer zero is also tricky, because its sign bit must lose to the integer flag. The stimulus sends hand-built encodings for each of these pairs back to back. Between them it sends opposite-signed zeros in all four rounding modes, so that the sign of the zero result flips only in one mode.

// File: rtl/fadd_sc_pkg.sv
package fadd_sc_pkg;
  typedef enum logic [2:0] {
    CL_ZERO, CL_DENORM, CL_NORM, CL_INF, CL_QNAN, CL_SNAN, CL_UNSUP
  } op_class_e;

  localparam logic [1:0] RM_NEAREST = 2'b00;
  localparam logic [1:0] RM_DOWN    = 2'b01;
  localparam logic [1:0] RM_UP      = 2'b10;
  localparam logic [1:0] RM_TOZERO  = 2'b11;
endpackage

// File: rtl/fadd_sc_classify.sv
module fadd_sc_classify
  import fadd_sc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op_i,
  input  logic         force_pos_zero_i,
  output op_class_e    cls_o,
  output logic [W-1:0] op_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] sig_f;

  assign exp_f = op_i[W-2:MAN_W];
  assign sig_f = op_i[MAN_W-1:0];

  always_comb begin
    if (exp_f == '0) begin
      cls_o = (sig_f == '0) ? CL_ZERO : CL_DENORM;
    end else if (exp_f == '1) begin
      if (!sig_f[MAN_W-1])             cls_o = CL_UNSUP;
      else if (sig_f[MAN_W-2:0] == '0) cls_o = CL_INF;
      else if (sig_f[MAN_W-2])         cls_o = CL_QNAN;
      else                             cls_o = CL_SNAN;
    end else begin
      cls_o = sig_f[MAN_W-1] ? CL_NORM : CL_UNSUP;
    end
  end

  // integer zero carries no sign
  always_comb begin
    op_o = op_i;
    if (force_pos_zero_i && cls_o == CL_ZERO) op_o[W-1] = 1'b0;
  end
endmodule

// File: rtl/fadd_sc_resolve.sv
module fadd_sc_resolve
  import fadd_sc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  op_class_e    cls_a_i,
  input  op_class_e    cls_b_i,
  input  logic [1:0]   rm_i,
  output logic         special_o,
  output logic [W-1:0] result_o,
  output logic         ia_o,
  output logic         d_o
);
  localparam logic [W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};
  localparam logic [W-1:0] QBIT  = {{(W-MAN_W+1){1'b0}}, 1'b1, {(MAN_W-2){1'b0}}};

  logic a_nan, b_nan, a_uns, b_uns, a_inf, b_inf, a_zero, b_zero, any_sig;

  assign a_nan  = (cls_a_i == CL_QNAN) || (cls_a_i == CL_SNAN);
  assign b_nan  = (cls_b_i == CL_QNAN) || (cls_b_i == CL_SNAN);
  assign a_uns  = (cls_a_i == CL_UNSUP);
  assign b_uns  = (cls_b_i == CL_UNSUP);
  assign a_inf  = (cls_a_i == CL_INF);
  assign b_inf  = (cls_b_i == CL_INF);
  assign a_zero = (cls_a_i == CL_ZERO);
  assign b_zero = (cls_b_i == CL_ZERO);
  assign any_sig = (cls_a_i == CL_SNAN) || (cls_b_i == CL_SNAN) || a_uns || b_uns;

  always_comb begin
    special_o = 1'b1;
    result_o  = a_i;
    ia_o      = any_sig;
    if (a_nan && b_nan) begin
      result_o = ((b_i[MAN_W-1:0] > a_i[MAN_W-1:0]) ? b_i : a_i) | QBIT;
    end else if (a_nan) begin
      result_o = a_i | QBIT;
    end else if (b_nan) begin
      result_o = b_i | QBIT;
    end else if (a_uns || b_uns) begin
      result_o = INDEF;
    end else if (a_inf && b_inf) begin
      if (a_i[W-1] != b_i[W-1]) begin
        ia_o     = 1'b1;
        result_o = INDEF;
      end
    end else if (a_inf) begin
      result_o = a_i;
    end else if (b_inf) begin
      result_o = b_i;
    end else if (a_zero && b_zero) begin
      if (a_i[W-1] != b_i[W-1]) result_o = {rm_i == RM_DOWN, {(W-1){1'b0}}};
    end else if (a_zero) begin
      result_o = b_i;
    end else if (b_zero) begin
      result_o = a_i;
    end else begin
      special_o = 1'b0;
    end
  end

  assign d_o = ((cls_a_i == CL_DENORM) || (cls_b_i == CL_DENORM)) &&
               !(a_nan || b_nan || a_uns || b_uns);
endmodule

// File: rtl/fadd_special_unit.sv
module fadd_special_unit
  import fadd_sc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic         src_int_i,
  input  logic [1:0]   round_mode_i,
  output logic         spec_valid_o,
  output logic [W-1:0] spec_result_o,
  output logic         use_adder_o,
  output logic         flag_ia_o,
  output logic         flag_d_o
);
  localparam logic [W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(MAN_W-2){1'b0}}};

  logic [W-1:0] raw_op [2];
  logic [W-1:0] fix_op [2];
  op_class_e    cls    [2];
  logic [1:0]   force_z;

  assign raw_op[0] = dst_i;
  assign raw_op[1] = src_i;
  assign force_z   = {src_int_i, 1'b0};

  for (genvar k = 0; k < 2; k++) begin : g_cls
    fadd_sc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op_i             (raw_op[k]),
      .force_pos_zero_i (force_z[k]),
      .cls_o            (cls[k]),
      .op_o             (fix_op[k])
    );
  end

  logic         special_c, ia_c, d_c;
  logic [W-1:0] result_c;

  fadd_sc_resolve #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_res (
    .a_i       (fix_op[0]),
    .b_i       (fix_op[1]),
    .cls_a_i   (cls[0]),
    .cls_b_i   (cls[1]),
    .rm_i      (round_mode_i),
    .special_o (special_c),
    .result_o  (result_c),
    .ia_o      (ia_c),
    .d_o       (d_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spec_valid_o  <= 1'b0;
      use_adder_o   <= 1'b0;
      flag_ia_o     <= 1'b0;
      flag_d_o      <= 1'b0;
      spec_result_o <= '0;
    end else begin
      spec_valid_o <= in_valid_i && special_c;
      use_adder_o  <= in_valid_i && !special_c;
      flag_ia_o    <= in_valid_i && ia_c;
      flag_d_o     <= in_valid_i && d_c;
      if (in_valid_i) spec_result_o <= special_c ? result_c : '0;
    end
  end

  // R1
  strobe_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> (spec_valid_o ^ use_adder_o));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !(spec_valid_o || use_adder_o || flag_ia_o || flag_d_o));
  // R2
  adder_no_ia_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_adder_o |-> !flag_ia_o);
  // R4
  inf_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && cls[0] == CL_INF && cls[1] == CL_INF && dst_i[W-1] != src_i[W-1])
    |=> (flag_ia_o && spec_result_o == INDEF));
  // R6
  zero_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && cls[0] == CL_ZERO && cls[1] == CL_ZERO &&
     fix_op[0][W-1] != fix_op[1][W-1] && round_mode_i == RM_DOWN)
    |=> (spec_valid_o && spec_result_o[W-1]));
  // R11
  unsup_ia_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (cls[0] == CL_UNSUP || cls[1] == CL_UNSUP)) |=> flag_ia_o);
endmodule

// File: tb/fadd_special_unit_tb_top.sv
module fadd_special_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [79:0] P1    = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] N1    = 80'hBFFF_8000_0000_0000_0000;
  localparam logic [79:0] P2    = 80'h4000_8000_0000_0000_0000;
  localparam logic [79:0] PZ    = 80'h0000_0000_0000_0000_0000;
  localparam logic [79:0] NZ    = 80'h8000_0000_0000_0000_0000;
  localparam logic [79:0] PINF  = 80'h7FFF_8000_0000_0000_0000;
  localparam logic [79:0] NINF  = 80'hFFFF_8000_0000_0000_0000;
  localparam logic [79:0] QN    = 80'h7FFF_C000_0000_0000_1234;
  localparam logic [79:0] SN    = 80'h7FFF_8000_0000_0000_0005;
  localparam logic [79:0] SNQ   = 80'h7FFF_C000_0000_0000_0005;
  localparam logic [79:0] QA    = 80'hFFFF_C000_0000_0000_0001;
  localparam logic [79:0] QB    = 80'h7FFF_C000_0000_0000_0002;
  localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;
  localparam logic [79:0] DEN   = 80'h0000_0000_0000_0000_0001;
  localparam logic [79:0] UNN   = 80'h3FFF_4000_0000_0000_0000;

  typedef struct {
    logic        spec;
    logic        use_add;
    logic [79:0] res;
    logic        ia;
    logic        d;
    string       tag;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic [79:0] dst_i = '0;
  logic [79:0] src_i = '0;
  logic src_int_i = 1'b0;
  logic [1:0] round_mode_i = 2'b00;
  logic spec_valid_o, use_adder_o, flag_ia_o, flag_d_o;
  logic [79:0] spec_result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fadd_special_unit dut_i (
    .clk_i, .rst_ni, .in_valid_i, .dst_i, .src_i, .src_int_i, .round_mode_i,
    .spec_valid_o, .spec_result_o, .use_adder_o, .flag_ia_o, .flag_d_o
  );

  task automatic send(input logic [79:0] d, input logic [79:0] s, input logic si,
                      input logic [1:0] rm, input logic e_spec, input logic [79:0] e_res,
                      input logic e_ia, input logic e_d, input string tag);
    exp_t e;
    @(negedge clk_i);
    dst_i = d; src_i = s; src_int_i = si; round_mode_i = rm; in_valid_i = 1'b1;
    e.spec = e_spec; e.use_add = !e_spec; e.res = e_res; e.ia = e_ia; e.d = e_d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && (spec_valid_o || use_adder_o)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected strobe spec=%0b use=%0b expected none", spec_valid_o, use_adder_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (spec_valid_o !== e.spec || use_adder_o !== e.use_add || flag_ia_o !== e.ia ||
            flag_d_o !== e.d || (e.spec && spec_result_o !== e.res)) begin
          errors++;
          $display("FAIL %s act spec=%0b use=%0b ia=%0b d=%0b res=%h exp spec=%0b use=%0b ia=%0b d=%0b res=%h",
                   e.tag, spec_valid_o, use_adder_o, flag_ia_o, flag_d_o, spec_result_o,
                   e.spec, e.use_add, e.ia, e.d, e.res);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (spec_valid_o || use_adder_o || flag_ia_o || flag_d_o || spec_result_o !== '0) begin
      errors++;
      $display("FAIL R1 reset state act=%0b%0b%0b%0b res=%h exp=0000 res=0",
               spec_valid_o, use_adder_o, flag_ia_o, flag_d_o, spec_result_o);
    end

    send(P1, P2, 0, 2'b00, 0, '0, 0, 0, "R2 normal+normal");
    send(PINF, PINF, 0, 2'b00, 1, PINF, 0, 0, "R3 +inf+inf");
    send(NINF, NINF, 0, 2'b01, 1, NINF, 0, 0, "R3 -inf-inf");
    send(PINF, NINF, 0, 2'b00, 1, INDEF, 1, 0, "R4 inf clash");
    send(NINF, PINF, 0, 2'b10, 1, INDEF, 1, 0, "R4 inf clash rev");
    idle();
    send(PINF, N1, 0, 2'b00, 1, PINF, 0, 0, "R5 inf+finite");
    send(N1, NINF, 0, 2'b00, 1, NINF, 0, 0, "R5 finite+inf");
    send(NZ, PINF, 0, 2'b00, 1, PINF, 0, 0, "R5 zero+inf");
    send(PZ, NZ, 0, 2'b00, 1, PZ, 0, 0, "R6 opp zeros rm00");
    send(PZ, NZ, 0, 2'b01, 1, NZ, 0, 0, "R6 opp zeros rm01");
    send(NZ, PZ, 0, 2'b10, 1, PZ, 0, 0, "R6 opp zeros rm10");
    send(NZ, PZ, 0, 2'b11, 1, PZ, 0, 0, "R6 opp zeros rm11");
    send(NZ, NZ, 0, 2'b00, 1, NZ, 0, 0, "R6 same neg zeros");
    send(NZ, NZ, 1, 2'b00, 1, PZ, 0, 0, "R7 int zero src");
    send(NZ, NZ, 1, 2'b01, 1, NZ, 0, 0, "R7 int zero src rm01");
    send(P2, PZ, 0, 2'b00, 1, P2, 0, 0, "R8 finite+zero");
    send(NZ, N1, 0, 2'b01, 1, N1, 0, 0, "R8 zero+finite");
    idle();
    idle();
    send(QN, P1, 0, 2'b00, 1, QN, 0, 0, "R9 qnan pass");
    send(P1, SN, 0, 2'b00, 1, SNQ, 1, 0, "R9 snan quiet");
    send(QN, NINF, 0, 2'b00, 1, QN, 0, 0, "R9 qnan+inf");
    send(SN, QN, 0, 2'b00, 1, QN, 1, 0, "R10 snan vs qnan");
    send(QA, QB, 0, 2'b00, 1, QB, 0, 0, "R10 larger src");
    send(QB, QA, 0, 2'b00, 1, QB, 0, 0, "R10 larger dst");
    send(SN, SN, 0, 2'b00, 1, SNQ, 1, 0, "R10 tie");
    send(UNN, P1, 0, 2'b00, 1, INDEF, 1, 0, "R11 unnormal");
    send(P1, UNN, 0, 2'b00, 1, INDEF, 1, 0, "R11 unnormal src");
    send(UNN, QN, 0, 2'b00, 1, QN, 1, 0, "R11 unsup+qnan");
    send(DEN, P1, 0, 2'b00, 0, '0, 0, 1, "R12 denorm to adder");
    send(PINF, DEN, 0, 2'b00, 1, PINF, 0, 1, "R12 denorm+inf");
    send(PZ, DEN, 0, 2'b00, 1, DEN, 0, 1, "R12 zero+denorm");
    send(SN, DEN, 0, 2'b00, 1, SNQ, 1, 0, "R12 snan suppresses D");
    send(N1, P1, 0, 2'b11, 0, '0, 0, 0, "R2 opposite finite");
    idle();
    repeat (4) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results act=%0d pending exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule